// File: doc/BRIEF.md
# Step Clock Conditioner and Edge Qualifier

This block sits between the raw step clock of a stepping-motor driver and its phase sequencer. It brings the asynchronous step clock, the rotation direction, the excitation-mode bits and the edge-timing bit into the system clock domain. Each input passes through a two-flop synchroniser. The step clock then goes through a counting glitch filter: a new level is accepted only once it has held for `FILT_N` consecutive samples.

Each accepted level change of the step clock can become a one-cycle step strobe. With the edge-timing bit set, only rising changes produce a strobe. With the bit clear, both rising and falling changes produce one. In the cycle that a strobe is issued, the block latches the synchronised direction, excitation mode and edge-timing bit, so the sequencer always works from settings that were steady around the edge.

A run-enable input acts as a clock enable. While it is low, every sampling register holds its value and no strobes or captures occur. The asynchronous reset can come from a power-on request or from an external pin, chosen by a select input. Once the chosen reset releases, a stretcher keeps the sequencer reset output low for `STRETCH` further clock edges.

Top module: `step_cond`

## Requirements
- R1: While the selected reset is low, step_pulse, step_level, dir_q, exc_q, rise_only_q and seq_rst_n are all 0.
- R2: When rst_src_ext is 1, only ext_rst_n resets the block and por_n has no effect. When rst_src_ext is 0, only por_n resets it.
- R3: After the selected reset goes high, seq_rst_n stays 0 through the first STRETCH-1 rising clock edges and becomes 1 at edge STRETCH. It then stays 1 until the next reset.
- R4: A step_in level change that persists is reflected in step_level, and in a qualifying step_pulse, exactly FILT_N+2 rising edges after the change (two synchroniser stages plus FILT_N filter samples).
- R5: A step_in level that lasts fewer than FILT_N clock cycles does not change step_level and produces no step_pulse. A level lasting FILT_N cycles is accepted.
- R6: When the synchronised edge-timing input rise_only_in is 1, only accepted 0-to-1 changes of step_level produce a step_pulse.
- R7: When rise_only_in is 0, both accepted 0-to-1 and accepted 1-to-0 changes of step_level produce a step_pulse.
- R8: step_pulse is never high for two consecutive cycles.
- R9: dir_q, exc_q and rise_only_q change only in the cycle that step_pulse is high. They take the values of dir_in, exc_in and rise_only_in after the same two-stage synchronisation that step_in sees.
- R10: While run_en is 0, no step_pulse occurs, the captured settings hold, and the synchronisers and filter hold their state. A step_in level change made while run_en is 0 is accepted after run_en returns to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| por_n | input | 1 | Power-on reset request, active low |
| ext_rst_n | input | 1 | External reset pin, active low |
| rst_src_ext | input | 1 | 1 selects ext_rst_n as the reset source, 0 selects por_n |
| run_en | input | 1 | Clock enable; 0 freezes sampling, strobes and captures |
| step_in | input | 1 | Asynchronous step clock |
| dir_in | input | 1 | Rotation direction setting |
| exc_in | input | EXC_W | Excitation mode setting |
| rise_only_in | input | 1 | Edge-timing bit: 1 strobes on rising edges only, 0 on both edges |
| step_pulse | output | 1 | One-cycle step strobe |
| step_level | output | 1 | Filtered step clock level |
| dir_q | output | 1 | Direction latched at the last strobe |
| exc_q | output | EXC_W | Excitation mode latched at the last strobe |
| rise_only_q | output | 1 | Edge-timing bit latched at the last strobe |
| seq_rst_n | output | 1 | Stretched sequencer reset, active low |

## Verification
The bench builds the block with FILT_N=4 and STRETCH=6. These small values let it test both sides of the filter threshold, with pulses of three and four cycles, and let it see the reset-release edge of the stretcher within a few cycles of each reset. The short depth also lets the exact FILT_N+2 latency be measured from a single input change. In the same run, the bench covers several full step periods in each edge mode, a freeze and resume under run_en, and switching between the two reset sources.

// File: rtl/step_cond_pkg.sv
package step_cond_pkg;

  // A freshly accepted level yields a strobe unless it is a fall in rise-only mode.
  function automatic logic step_qualifies(input logic new_lvl, input logic rise_only);
    return new_lvl | ~rise_only;
  endfunction

  // Counter width that can hold the values 0 .. n-1 (at least one bit).
  function automatic int cnt_bits(input int n);
    return (n <= 2) ? 1 : $clog2(n);
  endfunction

endpackage

// File: rtl/step_sync_chain.sv
module step_sync_chain #(
  parameter int WIDTH  = 1,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             arst_n,
  input  logic             hold_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  localparam int TOTAL = WIDTH * STAGES;

  logic [TOTAL-1:0] shift_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      shift_q <= '0;
    end else if (hold_n) begin
      shift_q <= {shift_q[TOTAL-WIDTH-1:0], d};
    end
  end

  assign q = shift_q[TOTAL-1 -: WIDTH];
endmodule

// File: rtl/step_level_filter.sv
module step_level_filter #(
  parameter int FILT_N = 8
) (
  input  logic clk,
  input  logic arst_n,
  input  logic hold_n,
  input  logic smp,
  output logic lvl,
  output logic accept
);
  localparam int CW = step_cond_pkg::cnt_bits(FILT_N);
  localparam logic [CW-1:0] LAST = CW'(FILT_N - 1);

  logic [CW-1:0] run_q;
  logic          differs;

  assign differs = (smp != lvl);
  assign accept  = hold_n && differs && (run_q == LAST);

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      run_q <= '0;
      lvl   <= 1'b0;
    end else if (hold_n) begin
      if (!differs) begin
        run_q <= '0;
      end else if (run_q == LAST) begin
        run_q <= '0;
        lvl   <= smp;
      end else begin
        run_q <= run_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/step_rst_stretch.sv
module step_rst_stretch #(
  parameter int STRETCH = 1000
) (
  input  logic clk,
  input  logic arst_n,
  output logic ready
);
  localparam int CW = step_cond_pkg::cnt_bits(STRETCH);
  localparam logic [CW-1:0] LAST = CW'(STRETCH - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      cnt_q <= '0;
      ready <= 1'b0;
    end else if (!ready) begin
      if (cnt_q == LAST) ready <= 1'b1;
      else               cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/step_cond.sv
module step_cond #(
  parameter int FILT_N      = 64,
  parameter int STRETCH     = 1000,
  parameter int EXC_W       = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             por_n,
  input  logic             ext_rst_n,
  input  logic             rst_src_ext,
  input  logic             run_en,
  input  logic             step_in,
  input  logic             dir_in,
  input  logic [EXC_W-1:0] exc_in,
  input  logic             rise_only_in,
  output logic             step_pulse,
  output logic             step_level,
  output logic             dir_q,
  output logic [EXC_W-1:0] exc_q,
  output logic             rise_only_q,
  output logic             seq_rst_n
);
  localparam int CAP_W = EXC_W + 2;

  logic             arst_n;
  logic             step_s;
  logic [CAP_W-1:0] set_s;
  logic [CAP_W-1:0] cap_q;
  logic             accept;
  logic             qualify;

  // Reset source: the selected pin is the only asynchronous reset.
  assign arst_n = rst_src_ext ? ext_rst_n : por_n;

  step_sync_chain #(.WIDTH(1), .STAGES(SYNC_STAGES)) u_step_sync (
    .clk(clk), .arst_n(arst_n), .hold_n(run_en), .d(step_in), .q(step_s)
  );

  // Settings layout: {direction, excitation mode, edge-timing bit}
  step_sync_chain #(.WIDTH(CAP_W), .STAGES(SYNC_STAGES)) u_set_sync (
    .clk(clk), .arst_n(arst_n), .hold_n(run_en),
    .d({dir_in, exc_in, rise_only_in}), .q(set_s)
  );

  step_level_filter #(.FILT_N(FILT_N)) u_filter (
    .clk(clk), .arst_n(arst_n), .hold_n(run_en),
    .smp(step_s), .lvl(step_level), .accept(accept)
  );

  step_rst_stretch #(.STRETCH(STRETCH)) u_stretch (
    .clk(clk), .arst_n(arst_n), .ready(seq_rst_n)
  );

  assign qualify = accept && step_cond_pkg::step_qualifies(step_s, set_s[0]);

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      step_pulse <= 1'b0;
      cap_q      <= '0;
    end else begin
      step_pulse <= qualify;
      if (qualify) cap_q <= set_s;
    end
  end

  assign dir_q       = cap_q[CAP_W-1];
  assign exc_q       = cap_q[EXC_W:1];
  assign rise_only_q = cap_q[0];
endmodule

// File: rtl/step_cond_chk.sv
module step_cond_chk #(
  parameter int EXC_W = 2
) (
  input logic             clk,
  input logic             arst_n,
  input logic             run_en,
  input logic             step_pulse,
  input logic             step_level,
  input logic             dir_q,
  input logic [EXC_W-1:0] exc_q,
  input logic             rise_only_q,
  input logic             seq_rst_n
);
  p_single_cycle_r8: assert property (@(posedge clk) disable iff (!arst_n)
    step_pulse |=> !step_pulse);

  p_quiet_when_off_r10: assert property (@(posedge clk) disable iff (!arst_n)
    !run_en |=> !step_pulse);

  p_hold_when_off_r10: assert property (@(posedge clk) disable iff (!arst_n)
    !run_en |=> ($stable(dir_q) && $stable(exc_q) && $stable(rise_only_q)));

  p_capture_on_strobe_r9: assert property (@(posedge clk) disable iff (!arst_n)
    !$stable({dir_q, exc_q, rise_only_q}) |-> step_pulse);

  p_strobe_follows_level_r4: assert property (@(posedge clk) disable iff (!arst_n)
    step_pulse |-> (step_level != $past(step_level)));

  p_rise_only_r6: assert property (@(posedge clk) disable iff (!arst_n)
    (step_pulse && rise_only_q) |-> step_level);

  p_release_sticky_r3: assert property (@(posedge clk) disable iff (!arst_n)
    seq_rst_n |=> seq_rst_n);
endmodule

bind step_cond step_cond_chk #(.EXC_W(EXC_W)) u_chk (
  .clk(clk), .arst_n(arst_n), .run_en(run_en), .step_pulse(step_pulse),
  .step_level(step_level), .dir_q(dir_q), .exc_q(exc_q),
  .rise_only_q(rise_only_q), .seq_rst_n(seq_rst_n)
);

// File: tb/tb_step_cond.sv
module tb_step_cond;
  localparam int FILT_N  = 4;
  localparam int STRETCH = 6;
  localparam int EXC_W   = 2;

  logic clk = 1'b0;
  logic por_n = 1'b0, ext_rst_n = 1'b1, rst_src_ext = 1'b0, run_en = 1'b1;
  logic step_in = 1'b0, dir_in = 1'b0, rise_only_in = 1'b0;
  logic [EXC_W-1:0] exc_in = '0;
  logic step_pulse, step_level, dir_q, rise_only_q, seq_rst_n;
  logic [EXC_W-1:0] exc_q;

  always #5 clk = ~clk;

  step_cond #(.FILT_N(FILT_N), .STRETCH(STRETCH), .EXC_W(EXC_W)) dut (
    .clk(clk), .por_n(por_n), .ext_rst_n(ext_rst_n), .rst_src_ext(rst_src_ext),
    .run_en(run_en), .step_in(step_in), .dir_in(dir_in), .exc_in(exc_in),
    .rise_only_in(rise_only_in), .step_pulse(step_pulse), .step_level(step_level),
    .dir_q(dir_q), .exc_q(exc_q), .rise_only_q(rise_only_q), .seq_rst_n(seq_rst_n)
  );

  int checks = 0, errors = 0;
  int pulse_cnt = 0, dbl_cnt = 0;
  bit done = 0;
  logic prev_pulse = 1'b0;

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // Behavioural reference: history of two samples per input, run counters.
  logic rsel_n;
  assign rsel_n = rst_src_ext ? ext_rst_n : por_n;

  int h_step[2], h_dir[2], h_exc[2], h_rise[2];
  int m_lvl = 0, m_run = 0, m_scnt = 0, m_rdy = 0, m_pulse = 0;
  int m_dir = 0, m_exc = 0, m_rise = 0;

  always @(posedge clk or negedge rsel_n) begin
    if (!rsel_n) begin
      for (int i = 0; i < 2; i++) begin
        h_step[i] = 0; h_dir[i] = 0; h_exc[i] = 0; h_rise[i] = 0;
      end
      m_lvl = 0; m_run = 0; m_scnt = 0; m_rdy = 0; m_pulse = 0;
      m_dir = 0; m_exc = 0; m_rise = 0;
    end else begin
      if (m_rdy == 0) begin
        if (m_scnt == STRETCH - 1) m_rdy = 1;
        else m_scnt++;
      end
      m_pulse = 0;
      if (run_en) begin
        if (h_step[1] != m_lvl) begin
          m_run++;
          if (m_run == FILT_N) begin
            m_run = 0;
            m_lvl = h_step[1];
            if (m_lvl == 1 || h_rise[1] == 0) begin
              m_pulse = 1; m_dir = h_dir[1]; m_exc = h_exc[1]; m_rise = h_rise[1];
            end
          end
        end else begin
          m_run = 0;
        end
        h_step[1] = h_step[0]; h_step[0] = int'(step_in);
        h_dir[1]  = h_dir[0];  h_dir[0]  = int'(dir_in);
        h_exc[1]  = h_exc[0];  h_exc[0]  = int'(exc_in);
        h_rise[1] = h_rise[0]; h_rise[0] = int'(rise_only_in);
      end
    end
  end

  // Cycle compare and pulse bookkeeping, away from the active edge.
  always @(negedge clk) begin
    if (!done) begin
      chk("R4 step_pulse", int'(step_pulse), m_pulse);
      chk("R5 step_level", int'(step_level), m_lvl);
      chk("R9 dir_q", int'(dir_q), m_dir);
      chk("R9 exc_q", int'(exc_q), m_exc);
      chk("R9 rise_only_q", int'(rise_only_q), m_rise);
      chk("R3 seq_rst_n", int'(seq_rst_n), m_rdy);
      if (step_pulse) pulse_cnt++;
      if (step_pulse && prev_pulse) dbl_cnt++;
      prev_pulse = step_pulse;
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic finish_run();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  initial begin
    int p0, k;
    // R1: reset state
    cyc(3);
    #1;
    chk("R1 pulse", int'(step_pulse), 0);
    chk("R1 level", int'(step_level), 0);
    chk("R1 dir", int'(dir_q), 0);
    chk("R1 seqrst", int'(seq_rst_n), 0);
    @(posedge clk); #2;
    // R3: stretcher release edge
    por_n = 1'b1;
    repeat (STRETCH - 1) @(posedge clk);
    #3;
    chk("R3 still held", int'(seq_rst_n), 0);
    @(posedge clk); #3;
    chk("R3 released", int'(seq_rst_n), 1);
    @(posedge clk); #2;
    // R4: latency from input change to strobe
    rise_only_in = 1'b1; dir_in = 1'b1; exc_in = 2'd2;
    cyc(5);
    step_in = 1'b1;
    k = 0;
    while (k < 20) begin
      @(posedge clk); #3;
      k++;
      if (step_pulse) break;
    end
    chk("R4 latency", k, FILT_N + 2);
    @(posedge clk); #2;
    chk("R9 dir captured", int'(dir_q), 1);
    chk("R9 exc captured", int'(exc_q), 2);
    // R6: rise-only mode, three periods
    cyc(10);
    p0 = pulse_cnt;
    for (int i = 0; i < 3; i++) begin
      step_in = 1'b0; cyc(10);
      step_in = 1'b1; cyc(10);
    end
    step_in = 1'b0; cyc(12);
    chk("R6 rise-only pulses", pulse_cnt - p0, 3);
    // R7: both-edge mode
    rise_only_in = 1'b0; dir_in = 1'b0; exc_in = 2'd1;
    cyc(5);
    p0 = pulse_cnt;
    for (int i = 0; i < 3; i++) begin
      step_in = 1'b1; cyc(10);
      step_in = 1'b0; cyc(10);
    end
    cyc(2);
    chk("R7 both-edge pulses", pulse_cnt - p0, 6);
    chk("R9 dir new", int'(dir_q), 0);
    chk("R9 exc new", int'(exc_q), 1);
    chk("R9 rise bit", int'(rise_only_q), 0);
    // R5: glitch just below threshold, then exactly at threshold
    p0 = pulse_cnt;
    step_in = 1'b1; cyc(FILT_N - 1);
    step_in = 1'b0; cyc(12);
    chk("R5 short glitch pulses", pulse_cnt - p0, 0);
    chk("R5 level unchanged", int'(step_level), 0);
    p0 = pulse_cnt;
    step_in = 1'b1; cyc(FILT_N);
    step_in = 1'b0; cyc(12);
    chk("R5 threshold pulses", pulse_cnt - p0, 2);
    // R10: freeze under run_en
    run_en = 1'b0;
    step_in = 1'b1; dir_in = 1'b1;
    p0 = pulse_cnt;
    cyc(20);
    chk("R10 no pulse when off", pulse_cnt - p0, 0);
    chk("R10 dir held", int'(dir_q), 0);
    chk("R10 level held", int'(step_level), 0);
    run_en = 1'b1;
    cyc(15);
    chk("R10 accepted after resume", pulse_cnt - p0, 1);
    chk("R10 dir after resume", int'(dir_q), 1);
    // R2: reset source selection
    rst_src_ext = 1'b1;
    cyc(2);
    por_n = 1'b0;
    cyc(5);
    chk("R2 por ignored seqrst", int'(seq_rst_n), 1);
    chk("R2 por ignored dir", int'(dir_q), 1);
    ext_rst_n = 1'b0;
    cyc(2);
    chk("R2 ext reset seqrst", int'(seq_rst_n), 0);
    chk("R2 ext reset dir", int'(dir_q), 0);
    ext_rst_n = 1'b1;
    cyc(STRETCH + 2);
    chk("R3 release after ext", int'(seq_rst_n), 1);
    por_n = 1'b1;
    cyc(3);
    chk("R8 no double pulses", dbl_cnt, 0);
    finish_run();
  end
endmodule